// File: doc/BRIEF.md
# Masked Status Register Write Unit

This block executes the "move general register to status register" operation of a 32-bit processor core. It decodes the instruction word and checks the condition-pass input. It then writes selected byte lanes of a source operand into either the current program status word or the saved status word banked for the current exception mode.

The current status word lives inside the block, and its low five bits are the current mode. Privilege is derived from that mode. User mode may change only the flags, the greater-or-equal bits and the endianness bit. Any privileged write that would load an unknown mode leaves the mode as it was and sets an illegal-execution bit instead.

Reserved forms are a zero field mask, source index 15, or a saved-word write from User or System mode. Each of these either raises an undefined-instruction flag or retires as a no-operation. A static parameter chooses between the two. The register file, the condition evaluator and exception entry sit outside this block.

Top module: `psr_write_unit`

## Requirements
- R1: While reset is low, the current status word is 0x000000D3 (Supervisor, both interrupt masks set), every saved word is 0, and the undefined flag is 0.
- R2: A word is accepted only when all of the following hold: bits 31:28 differ from 1111, bits 27:23 equal 00010, bits 21:20 equal 10, and bits 7:4 equal 0000. Any other word changes no state and raises no flag.
- R3: When the condition-pass input is low, an accepted word changes no state and raises no flag.
- R4: Mask bit 3 enables byte 31:24, bit 2 enables byte 23:16, bit 1 enables byte 15:8, and bit 0 enables byte 7:0, where the mask is instruction bits 19:16. Bytes that are not enabled keep their value.
- R5: Instruction bit 22 set writes the saved word of the current mode's bank, which is one of FIQ, IRQ, Supervisor, Abort or Undefined. Bit 22 clear writes the current word. Each bank holds its value independently of the others.
- R6: A mask of 0000, or a source index of 15 (bits 3:0), changes no state. It raises the undefined flag when parameter TRAP_RSV is 1, and it raises nothing when TRAP_RSV is 0.
- R7: A saved-word write in User mode (10000) or System mode (11111) is treated as reserved under R6. No saved word changes.
- R8: In User mode a current-word write changes only bits 31:27, 19:16 and 9.
- R9: Bit 9 (endianness) is writable from every mode, including User.
- R10: Legal modes are 10000, 10001, 10010, 10011, 10111, 11011 and 11111. A privileged write of byte 7:0 carrying any other mode keeps the old mode and sets bit 20. A write of byte 7:0 with a legal mode clears bit 20. Bit 20 is never copied from the source.
- R11: Status words and the undefined flag update on the rising clock edge that samples the instruction. The saved-word output shows the bank of the current mode, and it reads 0 in User or System mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_vld | input | 1 | An instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result for this instruction |
| src_val | input | 32 | Value read from the named source register |
| cpsr_o | output | 32 | Current status word |
| saved_o | output | 32 | Saved status word of the current mode's bank |
| undef_o | output | 1 | Undefined-instruction flag for the previous cycle's instruction |

## Verification
Every result is due exactly one rising edge after the instruction is presented. The current word, the undefined flag and the saved-word view all appear together after that edge, because the saved-word view follows the mode held in the current word. The driver presents each instruction on a falling edge and queues its expected outcome. The monitor takes each outcome off the queue one time unit after the next rising edge and compares all three outputs. A second instance with TRAP_RSV set to 0 receives the same stimulus, so the no-operation choice for reserved forms is checked in the same cycles.

// File: rtl/psr_pkg.sv
// Shared definitions for the status register write unit: mode codes,
// write-request record and helper functions. Assumes 5-bit mode codes.
package psr_pkg;

    localparam int          XLEN       = 32;
    localparam int          LANES      = XLEN / 8;
    localparam int          NUM_BANKS  = 5;
    localparam int          BANK_W     = 3;
    localparam int          ILL_BIT    = 20;

    localparam logic [4:0]  MODE_USR   = 5'b10000;
    localparam logic [4:0]  MODE_FIQ   = 5'b10001;
    localparam logic [4:0]  MODE_IRQ   = 5'b10010;
    localparam logic [4:0]  MODE_SVC   = 5'b10011;
    localparam logic [4:0]  MODE_ABT   = 5'b10111;
    localparam logic [4:0]  MODE_UND   = 5'b11011;
    localparam logic [4:0]  MODE_SYS   = 5'b11111;

    localparam logic [XLEN-1:0] RESET_CPSR = 32'h0000_00D3;
    localparam logic [XLEN-1:0] USER_BITS  = 32'hF80F_0200;
    localparam logic [XLEN-1:0] PRIV_BITS  = ~(32'h1 << ILL_BIT);

    // Decoded write request.
    typedef struct packed {
        logic             hit;
        logic             to_saved;
        logic [LANES-1:0] lanes;
        logic             rsv;
    } wr_req_t;

    // True for a mode code the core recognises.
    function automatic logic mode_ok(input logic [4:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction

    // Bank index for a mode; NUM_BANKS or above means no bank.
    function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
        case (m)
            MODE_FIQ: return 3'd0;
            MODE_IRQ: return 3'd1;
            MODE_SVC: return 3'd2;
            MODE_ABT: return 3'd3;
            MODE_UND: return 3'd4;
            default:  return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/psr_decode.sv
// Instruction decoder: matches the fixed opcode bits and extracts the
// destination select, lane mask and the mode-independent reserved cases.
// Assumes a 32-bit word; purely combinational.
module psr_decode
    import psr_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output wr_req_t         req
);

    logic [3:0] cond;
    logic [3:0] rn;

    assign cond = insn[31:28];
    assign rn   = insn[3:0];

    // Field match and request extraction.
    always_comb begin
        req.hit      = (cond != 4'b1111) && (insn[27:23] == 5'b00010) &&
                       (insn[21:20] == 2'b10) && (insn[7:4] == 4'b0000);
        req.to_saved = insn[22];
        req.lanes    = insn[19:16];
        req.rsv      = (insn[19:16] == 4'b0000) || (rn == 4'd15);
    end

endmodule

// File: rtl/psr_merge.sv
// Builds the next current status word from the old value, the source
// operand and the lane mask, applying the privilege filter and the
// mode legality check. Combinational; the caller decides whether to load.
module psr_merge
    import psr_pkg::*;
(
    input  logic [XLEN-1:0]  cur,
    input  logic [XLEN-1:0]  src,
    input  logic [LANES-1:0] lanes,
    input  logic             priv,
    output logic [XLEN-1:0]  nxt
);

    logic [XLEN-1:0] lane_bits;
    logic [XLEN-1:0] wmask;
    logic            mode_wr;
    logic            mode_bad;

    // Expand each lane enable to its eight bits.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bits[8*i +: 8] = {8{lanes[i]}};
    end

    assign mode_wr  = priv && lanes[0];
    assign mode_bad = mode_wr && !mode_ok(src[4:0]);

    // Filter writable bits and merge, then resolve the illegal bit.
    always_comb begin
        wmask = lane_bits & (priv ? PRIV_BITS : USER_BITS);
        if (mode_bad) begin
            wmask[4:0] = 5'b0;
        end
        nxt = (cur & ~wmask) | (src & wmask);
        if (mode_bad) begin
            nxt[ILL_BIT] = 1'b1;
        end else if (mode_wr) begin
            nxt[ILL_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/psr_saved_bank.sv
// Banked saved status words, one per exception mode, with per-lane
// write enables. Synchronous active-low reset to zero. Read is
// combinational from the selected bank.
module psr_saved_bank
    import psr_pkg::*;
#(
    parameter int N = NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] sel,
    input  logic [LANES-1:0]  lanes,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   rd
);

    logic [XLEN-1:0] bank_q [N];

    for (genvar b = 0; b < N; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_byte
            // Load one byte of one bank when selected and enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q[b][8*l +: 8] <= 8'h00;
                end else if (we && (sel == BANK_W'(b)) && lanes[l]) begin
                    bank_q[b][8*l +: 8] <= src[8*l +: 8];
                end
            end
        end
    end

    // Read the selected bank; out-of-range gives zero.
    always_comb begin
        rd = '0;
        for (int b = 0; b < N; b++) begin
            if (sel == BANK_W'(b)) begin
                rd = bank_q[b];
            end
        end
    end

endmodule

// File: rtl/psr_write_unit.sv
// Top of the status register write unit. Holds the current status word,
// routes accepted writes to it or to the saved bank of the current mode,
// and flags reserved forms. TRAP_RSV=1 traps reserved forms, 0 ignores them.
module psr_write_unit
    import psr_pkg::*;
#(
    parameter bit TRAP_RSV = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_vld,
    input  logic [31:0]     insn,
    input  logic            cond_pass,
    input  logic [31:0]     src_val,
    output logic [31:0]     cpsr_o,
    output logic [31:0]     saved_o,
    output logic            undef_o
);

    wr_req_t           req;
    logic [XLEN-1:0]   cpsr_q;
    logic [XLEN-1:0]   cpsr_nxt;
    logic [XLEN-1:0]   bank_rd;
    logic [BANK_W-1:0] bank;
    logic              has_bank;
    logic              priv;
    logic              go;
    logic              rsv;
    logic              cpsr_we;
    logic              saved_we;
    logic              undef_q;

    psr_decode u_dec (
        .insn (insn),
        .req  (req)
    );

    assign priv     = (cpsr_q[4:0] != MODE_USR);
    assign bank     = bank_of(cpsr_q[4:0]);
    assign has_bank = (bank < BANK_W'(NUM_BANKS));

    assign go       = insn_vld && cond_pass && req.hit;
    assign rsv      = req.rsv || (req.to_saved && !has_bank);
    assign cpsr_we  = go && !rsv && !req.to_saved;
    assign saved_we = go && !rsv && req.to_saved;

    psr_merge u_merge (
        .cur   (cpsr_q),
        .src   (src_val),
        .lanes (req.lanes),
        .priv  (priv),
        .nxt   (cpsr_nxt)
    );

    psr_saved_bank #(.N(NUM_BANKS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (saved_we),
        .sel   (bank),
        .lanes (req.lanes),
        .src   (src_val),
        .rd    (bank_rd)
    );

    // Current status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q <= RESET_CPSR;
        end else if (cpsr_we) begin
            cpsr_q <= cpsr_nxt;
        end
    end

    // Undefined-instruction flag for reserved forms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_q <= 1'b0;
        end else begin
            undef_q <= go && rsv && TRAP_RSV;
        end
    end

    assign cpsr_o  = cpsr_q;
    assign saved_o = has_bank ? bank_rd : '0;
    assign undef_o = undef_q;

endmodule

// File: rtl/psr_write_unit_chk.sv
// Property checker for psr_write_unit, bound to every instance.
module psr_write_unit_chk
    import psr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        insn_vld,
    input logic        cond_pass,
    input logic [31:0] cpsr_o,
    input logic        undef_o
);

    // R6
    undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> $stable(cpsr_o));

    // R3
    cond_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && !cond_pass) |=> $stable(cpsr_o));

    // R8
    user_priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_o[4:0] == MODE_USR) |=>
            ((cpsr_o & ~USER_BITS) == ($past(cpsr_o) & ~USER_BITS)));

    // R10
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(cpsr_o[4:0]));

    // R10
    ill_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpsr_o[ILL_BIT]) |-> $stable(cpsr_o[4:0]));

endmodule

bind psr_write_unit psr_write_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_vld  (insn_vld),
    .cond_pass (cond_pass),
    .cpsr_o    (cpsr_o),
    .undef_o   (undef_o)
);

// File: tb/sim_psr_write_unit.sv
// Scoreboard bench: driver queues expected outcomes, monitor compares.
module sim_psr_write_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] cpsr;
        logic [31:0] saved;
        logic        undef;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld = 1'b0;
    logic [31:0] insn = '0;
    logic        cond_pass = 1'b0;
    logic [31:0] src_val = '0;
    logic [31:0] cpsr_o, saved_o, cpsr1, saved1;
    logic        undef_o, undef1;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_write_unit #(.TRAP_RSV(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
        .cond_pass(cond_pass), .src_val(src_val),
        .cpsr_o(cpsr_o), .saved_o(saved_o), .undef_o(undef_o));

    psr_write_unit #(.TRAP_RSV(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
        .cond_pass(cond_pass), .src_val(src_val),
        .cpsr_o(cpsr1), .saved_o(saved1), .undef_o(undef1));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(logic [3:0] cond, logic r,
                                        logic [3:0] mask, logic [3:0] rn);
        return {cond, 5'b00010, r, 2'b10, mask, 8'hF0, 4'b0000, rn};
    endfunction

    // Present one instruction and queue its expected outcome.
    task automatic issue(logic [31:0] w, logic cp, logic [31:0] s,
                         logic [31:0] ec, logic [31:0] es, logic eu, string tag);
        exp_t e;
        @(negedge clk);
        insn_vld  = 1'b1;
        insn      = w;
        cond_pass = cp;
        src_val   = s;
        e.cpsr = ec; e.saved = es; e.undef = eu; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one time unit after the sampling edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " cpsr"},  cpsr_o,  e.cpsr);
            chk({e.tag, " saved"}, saved_o, e.saved);
            chk({e.tag, " undef"}, {31'b0, undef_o}, {31'b0, e.undef});
            chk({e.tag, " R6 nop-variant undef"}, {31'b0, undef1}, 32'b0);
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cpsr",  cpsr_o,  32'h0000_00D3);
        chk("R1 saved", saved_o, 32'h0);
        chk("R1 undef", {31'b0, undef_o}, 32'b0);
        rst_n = 1'b1;

        issue(enc(4'hE,0,4'b1000,4'd1), 1, 32'hF800_0000, 32'hF800_00D3, 0, 0, "R4 flags lane");
        issue(enc(4'hE,0,4'b0100,4'd1), 1, 32'h001F_0000, 32'hF80F_00D3, 0, 0, "R4 R10 status lane");
        issue(enc(4'hE,0,4'b1111,4'd1), 0, 32'h0,         32'hF80F_00D3, 0, 0, "R3 cond fail");
        issue(enc(4'hE,0,4'b1111,4'd1) | 32'h10, 1, 32'h0, 32'hF80F_00D3, 0, 0, "R2 bad bits 7:4");
        issue(enc(4'hF,0,4'b1111,4'd1), 1, 32'h0,         32'hF80F_00D3, 0, 0, "R2 cond 1111");
        issue(enc(4'hE,0,4'b0000,4'd1), 1, 32'h0,         32'hF80F_00D3, 0, 1, "R6 zero mask");
        issue(enc(4'hE,0,4'b1000,4'd15),1, 32'h0,         32'hF80F_00D3, 0, 1, "R6 index 15");
        issue(enc(4'hE,1,4'b1111,4'd2), 1, 32'h1234_5678, 32'hF80F_00D3, 32'h1234_5678, 0, "R5 svc saved");
        issue(enc(4'hE,0,4'b0001,4'd2), 1, 32'h0000_0015, 32'hF81F_0013, 32'h1234_5678, 0, "R10 illegal mode");
        issue(enc(4'hE,0,4'b0001,4'd2), 1, 32'h0000_00D2, 32'hF80F_00D2, 0, 0, "R10 R11 to irq");
        issue(enc(4'hE,1,4'b0010,4'd3), 1, 32'h0000_AB00, 32'hF80F_00D2, 32'h0000_AB00, 0, "R4 R5 irq saved");
        issue(enc(4'hE,0,4'b0001,4'd3), 1, 32'h0000_00D3, 32'hF80F_00D3, 32'h1234_5678, 0, "R5 banks kept");
        issue(enc(4'hE,0,4'b0001,4'd3), 1, 32'h0000_001F, 32'hF80F_001F, 0, 0, "R11 to sys");
        issue(enc(4'hE,1,4'b1111,4'd3), 1, 32'hFFFF_FFFF, 32'hF80F_001F, 0, 1, "R7 sys saved");
        issue(enc(4'hE,0,4'b0001,4'd3), 1, 32'h0000_0010, 32'hF80F_0010, 0, 0, "R11 to usr");
        issue(enc(4'hE,0,4'b1111,4'd4), 1, 32'h07F0_FFEF, 32'h0000_0210, 0, 0, "R8 R9 user write");
        issue(enc(4'hE,1,4'b1111,4'd4), 1, 32'hFFFF_FFFF, 32'h0000_0210, 0, 1, "R7 usr saved");
        issue(enc(4'hE,0,4'b0010,4'd4), 1, 32'h0000_0000, 32'h0000_0010, 0, 0, "R9 user E clear");

        @(negedge clk);
        insn_vld = 1'b0;
        cond_pass = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 queue drained", q.size(), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule